// File: doc/BRIEF.md
# Motor Bridge Fault Protection Manager

This block sits between the fault comparators of an H-bridge power stage and its gate control. It turns the raw comparator levels (supply undervoltage, charge-pump undervoltage, overtemperature, and one overcurrent level per half-bridge) into one disable command per half-bridge and an active-low fault flag. The flag also carries the chop indicator from the current regulator.

Overcurrent and supply-undervoltage levels pass through counting deglitch filters, so short spikes are ignored. An overcurrent that survives its filter shuts the output down. The output then either comes back after a fixed retry window or stays off until the next sleep cycle. The choice between these two responses is captured while the block is asleep and held while it is awake.

In independent half-bridge operation, an overcurrent turns off only the half-bridge that saw it. Both half-bridges share one retry timer, and every new trip restarts it. All delays are parameters counted in clock cycles.

Top module: `mdrv_fault_mgr`

## Requirements
- R1: While sleep_n is low, and out of reset, both hb_disable bits are 1 and fault_n is 1.
- R2: An oc_raw bit that is high for fewer than OCP_DGL_CYC consecutive clock samples has no effect: hb_disable stays 00 and fault_n stays 1.
- R3: In bridge operation (independent flag captured as 0), an overcurrent held for OCP_DGL_CYC samples disables both half-bridges and drives fault_n low. The outputs change one cycle after the filter completes.
- R4: In retry response, the trip lasts exactly RETRY_CYC cycles. If the overcurrent is still present afterwards, it trips again after another full deglitch interval.
- R5: ocp_sel values 0 and 1 select retry, and values 2 and 3 select latched-off. In latched-off, a trip holds both the disable and fault_n=0 until sleep_n goes low.
- R6: In independent operation (captured flag 1), an overcurrent on half-bridge i sets only hb_disable[i]. Overcurrent on both half-bridges sets both bits.
- R7: In independent operation, a trip on the second half-bridge during the retry window restarts the shared timer. Both half-bridges re-enable together RETRY_CYC cycles after the latest trip.
- R8: vm_uv_raw held for UV_DGL_CYC samples disables both half-bridges and drives fault_n low. The bridge recovers one cycle after the level drops.
- R9: cp_uv_raw and ot_raw each disable both half-bridges and drive fault_n low in the same cycle. Each recovers as soon as its level clears.
- R10: chop_ind drives fault_n low while awake and never sets hb_disable. It is ignored while asleep.
- R11: ocp_sel and indep_mode are captured only while sleep_n is low. Changes while awake have no effect until the next sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_n | input | 1 | Wake request; low puts the bridge to sleep and clears trips |
| vm_uv_raw | input | 1 | Raw supply undervoltage comparator level |
| cp_uv_raw | input | 1 | Raw charge-pump undervoltage comparator level |
| ot_raw | input | 1 | Raw overtemperature comparator level |
| oc_raw | input | 2 | Raw overcurrent level, one bit per half-bridge |
| ocp_sel | input | 2 | Overcurrent response setting (0,1 retry; 2,3 latched) |
| indep_mode | input | 1 | Independent half-bridge operation flag |
| chop_ind | input | 1 | Current-chop indicator from the regulator |
| hb_disable | output | 2 | Disable command per half-bridge |
| fault_n | output | 1 | Active-low fault flag |

## Verification
The functions that collide are the overcurrent retry window and the other flag sources: the chop indicator and the automatically recovering undervoltage faults. The bench raises chop_ind and cp_uv_raw inside a running retry window and drops them again before the window expires. It then checks that the disable outcome is still set by the retry timer alone. A second collision is a new independent-mode trip arriving while the shared timer is already counting. In that case the bench expects the first half-bridge to stay off past its original expiry cycle, and computes that cycle from RETRY_CYC.

// File: rtl/mdrv_fault_pkg.sv
package mdrv_fault_pkg;

   localparam int unsigned NUM_HB = 2;

   typedef enum logic {
      OCP_RETRY = 1'b0,
      OCP_LATCH = 1'b1
   } ocp_resp_e;

   // Settings 0 and 1 retry, settings 2 and 3 latch off.
   function automatic ocp_resp_e ocp_resp_decode(input logic [1:0] sel);
      return (sel >= 2'd2) ? OCP_LATCH : OCP_RETRY;
   endfunction

endpackage

// File: rtl/mdrv_deglitch.sv
module mdrv_deglitch #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic lvl_in,
   output logic lvl_out
);

   initial assert (DEPTH >= 1) else $error("mdrv_deglitch: DEPTH must be at least 1");

   generate
      if (DEPTH == 1) begin : g_single
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= 1'b0;
            else          q <= lvl_in & ~clr;
         end
         assign lvl_out = q;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DEPTH + 1);
         localparam logic [CW-1:0] FULL = CW'(DEPTH);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                cnt_q <= '0;
            else if (clr || !lvl_in)   cnt_q <= '0;
            else if (cnt_q != FULL)    cnt_q <= cnt_q + 1'b1;
         end
         assign lvl_out = (cnt_q == FULL);
      end
   endgenerate

   // R2: a filtered level is only ever reported after the raw level was high
   assert_filtered_needs_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_out |-> $past(lvl_in));

endmodule

// File: rtl/mdrv_ocp_ctrl.sv
module mdrv_ocp_ctrl
   import mdrv_fault_pkg::*;
#(
   parameter int unsigned RETRY_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_n,
   input  logic [NUM_HB-1:0] oc_flt,
   input  logic              indep,
   input  logic              latch_mode,
   output logic [NUM_HB-1:0] ocp_dis
);

   initial assert (RETRY_CYC >= 2) else $error("mdrv_ocp_ctrl: RETRY_CYC must be at least 2");

   localparam int unsigned TW = $clog2(RETRY_CYC + 1);
   localparam logic [TW-1:0] RELOAD = TW'(RETRY_CYC);

   logic [NUM_HB-1:0] trip_q;
   logic [NUM_HB-1:0] new_ev;
   logic [NUM_HB-1:0] set_mask;
   logic [TW-1:0]     timer_q;
   logic              ev_any;
   logic              expire;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_HB; gi++) begin : g_event
         assign new_ev[gi] = oc_flt[gi] & ~trip_q[gi];

         // R5: in latched-off response a trip holds until sleep
         assert_latched_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !sleep_n)
            (latch_mode && trip_q[gi]) |=> trip_q[gi]);
      end
   endgenerate

   assign ev_any   = |new_ev;
   assign set_mask = indep ? new_ev : {NUM_HB{ev_any}};
   assign expire   = (timer_q == TW'(1)) && !latch_mode;

   always_ff @(posedge clk) begin
      if (!rst_n || !sleep_n) begin
         trip_q  <= '0;
         timer_q <= '0;
      end else if (ev_any) begin
         trip_q  <= trip_q | set_mask;
         timer_q <= RELOAD;
      end else if (timer_q != '0) begin
         if (expire) trip_q <= '0;
         timer_q <= timer_q - 1'b1;
      end
   end

   assign ocp_dis = trip_q;

   // R4: the shared retry timer never exceeds the retry window
   assert_timer_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      timer_q <= RELOAD);

   // R3: outside independent operation both half-bridges trip together
   assert_bridge_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !indep |-> (trip_q[0] == trip_q[1]));

endmodule

// File: rtl/mdrv_fault_mgr.sv
module mdrv_fault_mgr
   import mdrv_fault_pkg::*;
#(
   parameter int unsigned OCP_DGL_CYC = 300,
   parameter int unsigned UV_DGL_CYC  = 1000,
   parameter int unsigned RETRY_CYC   = 200000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_n,
   input  logic       vm_uv_raw,
   input  logic       cp_uv_raw,
   input  logic       ot_raw,
   input  logic [1:0] oc_raw,
   input  logic [1:0] ocp_sel,
   input  logic       indep_mode,
   input  logic       chop_ind,
   output logic [1:0] hb_disable,
   output logic       fault_n
);

   ocp_resp_e         resp_q;
   logic              indep_q;
   logic              vm_uv_f;
   logic [NUM_HB-1:0] oc_f;
   logic [NUM_HB-1:0] ocp_dis;
   logic              global_flt;

   // Response and operation flags are captured only while asleep (R11)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_q  <= OCP_RETRY;
         indep_q <= 1'b0;
      end else if (!sleep_n) begin
         resp_q  <= ocp_resp_decode(ocp_sel);
         indep_q <= indep_mode;
      end
   end

   mdrv_deglitch #(.DEPTH(UV_DGL_CYC)) u_vm_dgl (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (1'b0),
      .lvl_in (vm_uv_raw),
      .lvl_out(vm_uv_f)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_HB; gi++) begin : g_oc
         mdrv_deglitch #(.DEPTH(OCP_DGL_CYC)) u_oc_dgl (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (~sleep_n | ocp_dis[gi]),
            .lvl_in (oc_raw[gi]),
            .lvl_out(oc_f[gi])
         );
      end
   endgenerate

   mdrv_ocp_ctrl #(.RETRY_CYC(RETRY_CYC)) u_ocp (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_n   (sleep_n),
      .oc_flt    (oc_f),
      .indep     (indep_q),
      .latch_mode(resp_q == OCP_LATCH),
      .ocp_dis   (ocp_dis)
   );

   assign global_flt = vm_uv_f | cp_uv_raw | ot_raw;
   assign hb_disable = {NUM_HB{~sleep_n | global_flt}} | ocp_dis;
   assign fault_n    = ~(sleep_n & (global_flt | (|ocp_dis) | chop_ind));

   // R3: an awake, disabled half-bridge is always flagged
   assert_flag_on_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_n && (|hb_disable)) |-> !fault_n);

   // R11: captured response stays put while awake
   assert_resp_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_n && $past(sleep_n)) |-> $stable(resp_q));

endmodule

// File: tb/mdrv_fault_mgr_tb.sv
module mdrv_fault_mgr_tb;

   localparam int CLK_PERIOD = 10;
   localparam int OCP_N = 3;
   localparam int UV_N  = 5;
   localparam int RET   = 20;

   logic       clk = 1'b0;
   logic       rst_n, sleep_n, vm_uv_raw, cp_uv_raw, ot_raw, indep_mode, chop_ind;
   logic [1:0] oc_raw, ocp_sel;
   logic [1:0] hb_disable;
   logic       fault_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdrv_fault_mgr #(.OCP_DGL_CYC(OCP_N), .UV_DGL_CYC(UV_N), .RETRY_CYC(RET)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .vm_uv_raw(vm_uv_raw),
      .cp_uv_raw(cp_uv_raw), .ot_raw(ot_raw), .oc_raw(oc_raw), .ocp_sel(ocp_sel),
      .indep_mode(indep_mode), .chop_ind(chop_ind), .hb_disable(hb_disable),
      .fault_n(fault_n)
   );

   // observation word {fault_n, hb_disable[1], hb_disable[0]}
   localparam logic [2:0] RUN   = 3'b100;
   localparam logic [2:0] ALL   = 3'b011;
   localparam logic [2:0] SLEEP = 3'b111;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [2:0] exp);
      logic [2:0] act;
      act = {fault_n, hb_disable};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wake(input logic [1:0] sel, input logic ind);
      sleep_n = 1'b0; ocp_sel = sel; indep_mode = ind;
      step(2);
      sleep_n = 1'b1;
      step(1);
   endtask

   initial begin
      rst_n = 1'b0; sleep_n = 1'b0; vm_uv_raw = 1'b0; cp_uv_raw = 1'b0; ot_raw = 1'b0;
      oc_raw = 2'b00; ocp_sel = 2'd0; indep_mode = 1'b0; chop_ind = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
      check("R1 sleep state", SLEEP);

      wake(2'd0, 1'b0);
      check("R1 awake idle", RUN);

      // R2: every glitch width below the filter depth on each half-bridge
      for (int ch = 0; ch < 2; ch++) begin
         for (int w = 1; w < OCP_N; w++) begin
            oc_raw[ch] = 1'b1; step(w);
            oc_raw[ch] = 1'b0; step(2);
            check("R2 glitch ignored", RUN);
         end
      end

      // R3 and R4: bridge operation with retry, on each half-bridge
      for (int ch = 0; ch < 2; ch++) begin
         oc_raw[ch] = 1'b1;
         step(OCP_N);     check("R3 before deglitch end", RUN);
         step(1);         check("R3 both disabled", ALL);
         step(RET - 1);   check("R4 still in retry window", ALL);
         step(1);         check("R4 re-enabled after window", RUN);
         step(OCP_N);     check("R4 re-deglitch running", RUN);
         step(1);         check("R4 persistent overcurrent re-trips", ALL);
         // collision: chop and charge-pump UV inside the retry window
         chop_ind = 1'b1; cp_uv_raw = 1'b1; step(2);
         check("R10 chop inside retry window", ALL);
         chop_ind = 1'b0; cp_uv_raw = 1'b0;
         oc_raw[ch] = 1'b0;
         step(RET - 3);   check("R9 retry outlives cleared cp fault", ALL);
         step(1);         check("R4 recovered", RUN);
      end

      // R5: sweep over the response settings
      for (int s = 0; s < 4; s++) begin
         wake(2'(s), 1'b0);
         oc_raw[0] = 1'b1; step(OCP_N + 1);
         check("R5 trip", ALL);
         oc_raw[0] = 1'b0; step(RET + 2);
         check("R5 response per setting", (s >= 2) ? ALL : RUN);
      end
      sleep_n = 1'b0; step(1);
      check("R5 sleep releases latched trip", SLEEP);

      // R11: setting changed while awake is ignored
      wake(2'd2, 1'b0);
      ocp_sel = 2'd0; indep_mode = 1'b1;
      oc_raw[1] = 1'b1; step(OCP_N + 1);
      check("R11 bridge trip despite awake indep change", ALL);
      oc_raw[1] = 1'b0; step(RET + 5);
      check("R11 still latched", ALL);
      sleep_n = 1'b0; step(1);
      sleep_n = 1'b1; step(1);
      check("R11 new retry capture", RUN);

      // R6 and R7: independent operation
      wake(2'd1, 1'b1);
      oc_raw[1] = 1'b1; step(OCP_N + 1);
      check("R6 only half-bridge 1 off", 3'b010);
      oc_raw[1] = 1'b0; step(4);
      oc_raw[0] = 1'b1; step(OCP_N + 1);
      check("R7 second half-bridge trips", ALL);
      oc_raw[0] = 1'b0;
      step(RET - 1);   check("R7 timer restarted, both off", ALL);
      step(1);         check("R7 both re-enable together", RUN);
      oc_raw[0] = 1'b1; step(OCP_N + 1);
      check("R6 only half-bridge 0 off", 3'b001);
      oc_raw[0] = 1'b0; step(RET);
      check("R6 recovered", RUN);
      oc_raw = 2'b11; step(OCP_N + 1);
      check("R6 both off on double overcurrent", ALL);
      oc_raw = 2'b00; step(RET);
      check("R6 double recovered", RUN);

      // R8: supply undervoltage deglitch and recovery
      vm_uv_raw = 1'b1; step(UV_N - 1);
      check("R8 before deglitch end", RUN);
      step(1);         check("R8 bridge off", ALL);
      vm_uv_raw = 1'b0; step(1);
      check("R8 recovered", RUN);

      // R9: immediate faults
      cp_uv_raw = 1'b1; step(1); check("R9 cp uv off", ALL);
      cp_uv_raw = 1'b0; step(1); check("R9 cp uv recovered", RUN);
      ot_raw = 1'b1;    step(1); check("R9 overtemp off", ALL);
      ot_raw = 1'b0;    step(1); check("R9 overtemp recovered", RUN);

      // R10: chop indicator
      chop_ind = 1'b1; step(1); check("R10 chop flags only", 3'b000);
      sleep_n = 1'b0;  step(1); check("R10 chop ignored asleep", SLEEP);
      chop_ind = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule